// File: doc/BRIEF.md
# Triple Interval Timer Unit

Three interval timers for a sound coprocessor, sharing one prescaler. A clock-enable input marks each processor cycle. On every such cycle the prescaler adds a step size to a fine accumulator. The step size is set by two speed fields in a test register. The accumulator produces a fast stage-1 pulse every 384 accumulated units, which is 16 × 24 units, and 24 is the largest step. It produces a slow stage-1 pulse on every eighth fast pulse. Timer 2 is clocked by the fast pulse. Timers 0 and 1 are clocked by the slow pulse.

Each timer has an 8-bit target and an 8-bit stage-2 counter. When stage 2 reaches the target, it returns to zero and the 4-bit output count steps up by one. Software reads the output count through a byte-wide register port, and the read clears the count. An enable bit that goes from 0 to 1 restarts that timer from zero.

Top module: `sfx_timer_unit`

## Requirements
- R1: Writing address 0xFA, 0xFB or 0xFC sets the 8-bit target of timer 0, 1 or 2. Stage 2 counts stage-1 pulses up to the target, then returns to 0 and increments the output count. A target of 0 acts as 256.
- R2: A read at 0xFD, 0xFE or 0xFF returns {4'b0, count} of timer 0, 1 or 2 combinationally in the same cycle. Afterwards that count is 0.
- R3: Writes to 0xFD, 0xFE and 0xFF leave all counts unchanged.
- R4: Writing 0xF1 sets the timer enables: bit 0 for timer 0, bit 1 for timer 1, bit 2 for timer 2. A disabled timer's count does not change except when it is read.
- R5: When a timer's enable bit goes from 0 to 1, its stage-2 and stage-3 counters reset to 0. Writing 1 to an enable that is already 1 leaves both counters untouched.
- R6: A write to 0xF0 sets the step to (1 << d[7:6]) + (2 << d[5:4]), where d is the written byte. The step after reset is 3. Timer 2 advances once per 384 accumulated units, with the remainder carried over. Timers 0 and 1 advance once per 3072 units.
- R7: The prescaler accumulates only in cycles where tick_i is 1, TEST bit 3 (timers run) is 1 and TEST bit 0 (timers halt) is 0. TEST resets with bit 3 set and bit 0 clear.
- R8: The output count wraps from 15 to 0.
- R9: If a read-clear and an increment of the same count fall in the same cycle, the count becomes 1.
- R10: Reads at 0xF0, 0xF1, 0xFA, 0xFB and 0xFC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Processor-cycle clock enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears an output count) |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational |
| counts_o | output | 12 | Output counts {timer2, timer1, timer0} |

## Verification
The hardest case to produce is a read-clear that lands exactly on an increment. The bench resets the block and sets the largest step, so the fast pulse falls on every 16th tick. It runs a fixed number of ticks with the bus idle, then raises a read and a tick together on the cycle the pulse is due. The enable-rising case works the same way: stage 2 is left part-way to the target before the enable is toggled. The check then depends on whether the next wrap comes early or late.

// File: rtl/sfx_timer_pkg.sv
package sfx_timer_pkg;
  localparam int N_TMR      = 3;
  localparam int CNT_W      = 4;
  localparam int TGT_W      = 8;
  localparam int STEP_W     = 5;
  localparam int STEP_MAX   = 24;
  localparam int FAST_DIV   = 16;
  localparam int SLOW_RATIO = 8;
  localparam int FAST_LIMIT = FAST_DIV * STEP_MAX;
  localparam int RES_W      = $clog2(FAST_LIMIT + STEP_MAX);
  localparam int FAST_IDX   = 2;

  localparam logic [7:0] ADDR_TEST = 8'hF0;
  localparam logic [7:0] ADDR_CTRL = 8'hF1;
  localparam logic [7:0] ADDR_TGT0 = 8'hFA;
  localparam logic [7:0] ADDR_OUT0 = 8'hFD;

  function automatic logic [STEP_W-1:0] step_of(logic [1:0] clk_spd, logic [1:0] tmr_spd);
    logic [STEP_W:0] s;
    s = (6'd1 << clk_spd) + (6'd2 << tmr_spd);
    return s[STEP_W-1:0];
  endfunction
endpackage

// File: rtl/sfx_timer_prescale.sv
module sfx_timer_prescale
  import sfx_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              fast_o,
  output logic              slow_o
);
  localparam int SLOW_W = $clog2(SLOW_RATIO);

  logic [RES_W-1:0]  res_q, sum;
  logic [SLOW_W-1:0] slow_q;
  logic              wrap;

  assign sum    = res_q + RES_W'(step_i);
  assign wrap   = sum >= RES_W'(FAST_LIMIT);
  assign fast_o = adv_i & wrap;
  assign slow_o = fast_o & (slow_q == SLOW_W'(SLOW_RATIO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      slow_q <= '0;
    end else if (adv_i) begin
      res_q <= wrap ? sum - RES_W'(FAST_LIMIT) : sum;
      if (fast_o) slow_q <= (slow_q == SLOW_W'(SLOW_RATIO - 1)) ? '0 : slow_q + 1'b1;
    end
  end

  assert_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(res_q) && $stable(slow_q));
  assert_nopulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |-> !fast_o && !slow_o);
  assert_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q < RES_W'(FAST_LIMIT));
endmodule

// File: rtl/sfx_timer_chan.sv
module sfx_timer_chan
  import sfx_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tgt_we_i,
  input  logic             ctl_we_i,
  input  logic             en_bit_i,
  input  logic [TGT_W-1:0] wdata_i,
  input  logic             rd_clr_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             en_q, en_rise, adv, hit;
  logic [TGT_W-1:0] tgt_q, st2_q, st2_nxt;
  logic [CNT_W-1:0] st3_q;

  assign en_rise = ctl_we_i & en_bit_i & ~en_q;
  assign adv     = en_q & pulse_i;
  assign st2_nxt = st2_q + 1'b1;
  // target 0 matches after 256 steps through 8-bit wrap
  assign hit     = adv & (st2_nxt == tgt_q);
  assign cnt_o   = st3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      tgt_q <= '0;
      st2_q <= '0;
      st3_q <= '0;
    end else begin
      if (ctl_we_i) en_q  <= en_bit_i;
      if (tgt_we_i) tgt_q <= wdata_i;
      if (en_rise) begin
        st2_q <= '0;
        st3_q <= '0;
      end else begin
        if (adv) st2_q <= hit ? '0 : st2_nxt;
        if (rd_clr_i)  st3_q <= hit ? CNT_W'(1) : '0;
        else if (hit)  st3_q <= st3_q + 1'b1;
      end
    end
  end

  assert_rdclr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !hit) |=> st3_q == '0);
  assert_collide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && hit) |=> st3_q == CNT_W'(1));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !rd_clr_i && !en_rise) |=> $stable(st3_q) && $stable(st2_q));
  assert_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> (st2_q == '0) && (st3_q == '0));
  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !rd_clr_i && st3_q == '1) |=> st3_q == '0);
endmodule

// File: rtl/sfx_timer_unit.sv
module sfx_timer_unit
  import sfx_timer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic [11:0] counts_o
);
  logic              run_q, halt_q, adv, test_we, ctl_we, fast_p, slow_p;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  cnt [N_TMR];

  assign test_we = reg_wr_i & (reg_addr_i == ADDR_TEST);
  assign ctl_we  = reg_wr_i & (reg_addr_i == ADDR_CTRL);
  assign adv     = tick_i & run_q & ~halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b1;
      halt_q <= 1'b0;
      step_q <= step_of(2'd0, 2'd0);
    end else if (test_we) begin
      run_q  <= reg_wdata_i[3];
      halt_q <= reg_wdata_i[0];
      step_q <= step_of(reg_wdata_i[7:6], reg_wdata_i[5:4]);
    end
  end

  sfx_timer_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .step_i (step_q),
    .fast_o (fast_p),
    .slow_o (slow_p)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic pulse;
    if (i == FAST_IDX) begin : g_fast
      assign pulse = fast_p;
    end else begin : g_slow
      assign pulse = slow_p;
    end
    sfx_timer_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tgt_we_i (reg_wr_i & (reg_addr_i == 8'(ADDR_TGT0 + i))),
      .ctl_we_i (ctl_we),
      .en_bit_i (reg_wdata_i[i]),
      .wdata_i  (reg_wdata_i),
      .rd_clr_i (reg_rd_i & (reg_addr_i == 8'(ADDR_OUT0 + i))),
      .pulse_i  (pulse),
      .cnt_o    (cnt[i])
    );
    assign counts_o[i*CNT_W +: CNT_W] = cnt[i];
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_TMR; i++)
      if (reg_rd_i && reg_addr_i == 8'(ADDR_OUT0 + i)) reg_rdata_o = 8'(cnt[i]);
  end

  assert_outwr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i >= ADDR_OUT0 && !tick_i) |=> $stable(counts_o));
  assert_wronly_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i < ADDR_OUT0) |-> reg_rdata_o == 8'h00);
endmodule

// File: tb/sfx_timer_unit_bench.sv
module sfx_timer_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic [11:0] counts;
  int          n_run = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfx_timer_unit u_sfx_timer_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .counts_o(counts)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=<%0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int c(int i);
    return int'(counts[i*4 +: 4]);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 0; wr = 0; rd = 0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [7:0] a, output int v);
    @(negedge clk); rd = 1; addr = a; #1 v = int'(rdata);
    @(negedge clk); rd = 0;
  endtask

  task automatic run(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    chk("R2 reset counts", int'(counts), 0);
    rd_reg(8'hFD, v); chk("R2 reset read", v, 0);
  endtask

  task automatic t_fast_and_disabled();
    do_reset();
    wr_reg(8'hF0, 8'hF8); wr_reg(8'hFC, 8'd1); wr_reg(8'hFA, 8'd1); wr_reg(8'hF1, 8'h04);
    run(80);
    chk("R1 timer2 target1 80 ticks", c(2), 5);
    chk("R4 timer0 disabled", c(0), 0);
    chk("R4 timer1 disabled", c(1), 0);
  endtask

  task automatic t_target_zero();
    do_reset();
    wr_reg(8'hF0, 8'hF8); wr_reg(8'hFC, 8'd0); wr_reg(8'hF1, 8'h04);
    run(4095); chk("R1 target0 before 256", c(2), 0);
    run(1);    chk("R1 target0 at 256", c(2), 1);
  endtask

  task automatic t_slow();
    do_reset();
    wr_reg(8'hF0, 8'hF8); wr_reg(8'hFA, 8'd2); wr_reg(8'hFB, 8'd3); wr_reg(8'hF1, 8'h03);
    run(768);
    chk("R6 timer0 slow", c(0), 3);
    chk("R6 timer1 slow", c(1), 2);
    chk("R4 timer2 disabled", c(2), 0);
  endtask

  task automatic t_steps();
    do_reset();
    wr_reg(8'hFC, 8'd1); wr_reg(8'hF1, 8'h04);
    run(256); chk("R6 reset step 3", c(2), 2);
    do_reset();
    wr_reg(8'hF0, 8'h58); wr_reg(8'hFC, 8'd1); wr_reg(8'hF1, 8'h04);
    run(128); chk("R6 step 6", c(2), 2);
    do_reset();
    wr_reg(8'hF0, 8'h18); wr_reg(8'hFC, 8'd1); wr_reg(8'hF1, 8'h04);
    run(153); chk("R6 step 5 remainder", c(2), 1);
    run(1);   chk("R6 step 5 second", c(2), 2);
  endtask

  task automatic t_gate();
    do_reset();
    wr_reg(8'hF0, 8'h09); wr_reg(8'hFC, 8'd1); wr_reg(8'hF1, 8'h04);
    run(200); chk("R7 halt bit set", c(2), 0);
    wr_reg(8'hF0, 8'h00);
    run(200); chk("R7 run bit clear", c(2), 0);
    wr_reg(8'hF0, 8'hF8);
    run(16);  chk("R7 prescaler untouched", c(2), 1);
  endtask

  task automatic t_read_write();
    int v;
    do_reset();
    wr_reg(8'hF0, 8'hF8); wr_reg(8'hFC, 8'd1); wr_reg(8'hF1, 8'h04);
    run(80);
    wr_reg(8'hFF, 8'hAA); chk("R3 write 0xFF ignored", c(2), 5);
    wr_reg(8'hFD, 8'h0F); chk("R3 write 0xFD ignored", int'(counts), 12'h500);
    rd_reg(8'hFF, v);
    chk("R2 read value", v, 5);
    chk("R2 cleared", c(2), 0);
    rd_reg(8'hF0, v); chk("R10 TEST reads 0", v, 0);
    rd_reg(8'hF1, v); chk("R10 CTRL reads 0", v, 0);
    rd_reg(8'hFC, v); chk("R10 target reads 0", v, 0);
  endtask

  task automatic t_enable_edge();
    do_reset();
    wr_reg(8'hF0, 8'hF8); wr_reg(8'hFC, 8'd4); wr_reg(8'hF1, 8'h04);
    run(48); chk("R5 stage2 partial", c(2), 0);
    wr_reg(8'hF1, 8'h04);
    run(16); chk("R5 rewrite keeps stage2", c(2), 1);
    run(32);
    wr_reg(8'hF1, 8'h00); wr_reg(8'hF1, 8'h04);
    chk("R5 rise clears count", c(2), 0);
    run(48); chk("R5 rise clears stage2", c(2), 0);
    run(16); chk("R5 restart wrap", c(2), 1);
  endtask

  task automatic t_wrap();
    do_reset();
    wr_reg(8'hF0, 8'hF8); wr_reg(8'hFC, 8'd1); wr_reg(8'hF1, 8'h04);
    run(240); chk("R8 at 15", c(2), 15);
    run(32);  chk("R8 wrapped", c(2), 1);
  endtask

  task automatic t_collide();
    int v;
    do_reset();
    wr_reg(8'hF0, 8'hF8); wr_reg(8'hFC, 8'd1); wr_reg(8'hF1, 8'h04);
    run(31); chk("R9 before", c(2), 1);
    @(negedge clk); rd = 1; addr = 8'hFF; tick = 1; #1 v = int'(rdata);
    @(negedge clk); rd = 0; tick = 0;
    chk("R9 read value", v, 1);
    chk("R9 count after collision", c(2), 1);
  endtask

  initial begin
    t_reset();
    t_fast_and_disabled();
    t_target_zero();
    t_slow();
    t_steps();
    t_gate();
    t_read_write();
    t_enable_edge();
    t_wrap();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule